// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the sequence of column indices that a double-data-rate SDRAM controller presents to its data path for a single read or write burst. A start pulse carries the column of the column command, a burst length code and an ordering flag. From the following cycle the block shows one column index per data beat, along with a valid flag and a last flag. An enable pulse consumes the beat currently on the outputs.

Two beat orderings are supported at run time. In the wrapping order, the low bits count upward inside a window that is aligned to the burst length. In the XOR order, the beat number is XORed into those low bits. The upper column bits never change within a burst. A new start pulse may arrive at any time, including while a burst is running. It cuts off the running burst and begins the new one from its own column, which is how one column command interrupts another.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o and last_o are 0 and col_o is 0.
- R2: One cycle after a clock edge with start_i high, valid_o is 1 and col_o equals the start_col_i sampled at that edge.
- R3: Burst length code bl_code_i selects the number of beats: 2'b01 gives 2, 2'b10 gives 4, 2'b11 gives 8, and 2'b00 is treated as 2.
- R4: With order_i = 0 (wrap), beat i shows the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL.
- R5: With order_i = 1 (XOR), beat i shows the start column with its low log2(BL) bits XORed with i.
- R6: Column bits above the low log2(BL) bits equal those of the start column on every beat.
- R7: last_o is high exactly on beat BL-1. Once that beat is consumed by beat_en_i, valid_o drops on the next cycle.
- R8: While valid_o is high and beat_en_i and start_i are low, col_o, valid_o and last_o hold.
- R9: start_i takes priority over beat_en_i in the same cycle. A start during a burst abandons the old burst and shows beat 0 of the new one.
- R10: bl_code_i and order_i are sampled only at start. Changing them during a burst does not alter that burst's sequence or length.
- R11: beat_en_i while valid_o is low has no effect: valid_o stays 0 and col_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst using the inputs below |
| start_col_i | input | COL_W (9) | Column of the command |
| bl_code_i | input | 2 | Burst length code |
| order_i | input | 1 | 0 = wrap order, 1 = XOR order |
| beat_en_i | input | 1 | Consume the current beat |
| col_o | output | COL_W (9) | Column index of the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach is a start that lands partway through a burst, with beat_en_i also high in that cycle. In that case the block must drop the old beat index and its latched settings in favour of the new ones. The stimulus runs a length-8 burst for a few beats and then raises start_i together with beat_en_i, using a different length, order and column. It checks the whole new sequence, and then changes the length and order inputs during a later burst to confirm the values latched at start are kept. Ahead of these cases, every length code, both orders and all eight low start bits are swept with expected columns computed arithmetically.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;
endpackage

// File: rtl/bl_decode.sv
module bl_decode #(
  parameter int unsigned BEAT_W = 3
) (
  input  logic [1:0]        code_i,
  output logic [BEAT_W-1:0] mask_o
);
  logic [1:0] sel;
  always_comb begin
    sel    = (code_i == 2'b00) ? 2'b01 : code_i;  // reserved code -> 2 beats
    mask_o = BEAT_W'((32'd1 << sel) - 32'd1);
  end
endmodule

// File: rtl/col_mapper.sv
module col_mapper
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned BEAT_W = 3
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [BEAT_W-1:0] mask_i,
  input  order_e            order_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] low, wrap_low, xor_low, sel_low;
  always_comb begin
    low      = base_i[BEAT_W-1:0];
    wrap_low = ((low + beat_i) & mask_i) | (low & ~mask_i);
    xor_low  = low ^ (beat_i & mask_i);
    sel_low  = (order_i == ORD_XOR) ? xor_low : wrap_low;
    col_o    = {base_i[COL_W-1:BEAT_W], sel_low};
  end
endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [BEAT_W-1:0] mask_i,
  input  order_e            order_i,
  input  logic              beat_en_i,
  output logic [COL_W-1:0]  base_o,
  output logic [BEAT_W-1:0] nxt_beat_o,
  output logic [BEAT_W-1:0] mask_o,
  output order_e            order_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              adv_o
);
  logic [BEAT_W-1:0] beat_q, mask_q;
  logic [COL_W-1:0]  base_q;
  order_e            order_q;
  logic              valid_q;

  assign last_o     = valid_q && (beat_q == mask_q);
  assign adv_o      = valid_q && beat_en_i && !start_i;
  assign nxt_beat_o = beat_q + 1'b1;
  assign base_o     = base_q;
  assign mask_o     = mask_q;
  assign order_o    = order_q;
  assign valid_o    = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      order_q <= ORD_WRAP;
      valid_q <= 1'b0;
    end else if (start_i) begin
      beat_q  <= '0;
      mask_q  <= mask_i;
      base_q  <= start_col_i;
      order_q <= order_i;
      valid_q <= 1'b1;
    end else if (adv_o) begin
      if (last_o) valid_q <= 1'b0;
      else        beat_q  <= nxt_beat_o;
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned MAX_BL = 8,
  localparam int unsigned BEAT_W = $clog2(MAX_BL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_code_i,
  input  logic             order_i,
  input  logic             beat_en_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [BEAT_W-1:0] dec_mask, mask_q, nxt_beat;
  logic [COL_W-1:0]  base_q, nxt_col, col_q;
  order_e            order_q;
  logic              adv;

  bl_decode #(.BEAT_W(BEAT_W)) u_dec (.code_i(bl_code_i), .mask_o(dec_mask));

  beat_ctrl #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
    .mask_i(dec_mask), .order_i(order_e'(order_i)), .beat_en_i(beat_en_i),
    .base_o(base_q), .nxt_beat_o(nxt_beat), .mask_o(mask_q), .order_o(order_q),
    .valid_o(valid_o), .last_o(last_o), .adv_o(adv)
  );

  col_mapper #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_map (
    .base_i(base_q), .beat_i(nxt_beat), .mask_i(mask_q), .order_i(order_q),
    .col_o(nxt_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                col_q <= '0;
    else if (start_i)           col_q <= start_col_i;
    else if (adv && !last_o)    col_q <= nxt_col;
  end
  assign col_o = col_q;
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned BEAT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             beat_en_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i));
  a_r6_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && beat_en_i && !start_i && !last_o) |=>
      col_o[COL_W-1:BEAT_W] == $past(col_o[COL_W-1:BEAT_W]));
  a_r7_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o && beat_en_i && !start_i) |=> !valid_o);
  a_r7_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !last_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !beat_en_i && !start_i) |=> valid_o && $stable(col_o) && $stable(last_o));
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> !valid_o && $stable(col_o));
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .start_col_i(start_col_i),
  .beat_en_i(beat_en_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  localparam int COL_W = 9;
  logic clk = 0, rst_n = 0;
  logic start = 0, order = 0, beat_en = 0;
  logic [COL_W-1:0] scol = '0;
  logic [1:0] blc = 2'b00;
  logic [COL_W-1:0] col;
  logic valid, last;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  burst_col_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .bl_code_i(blc), .order_i(order), .beat_en_i(beat_en),
    .col_o(col), .valid_o(valid), .last_o(last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [1:0] c);
    return (c == 2'b00) ? 2 : (1 << c);
  endfunction

  function automatic int exp_col(input int c, input int bl, input bit xo, input int i);
    int m = bl - 1;
    if (xo) return c ^ i;
    return (c & ~m) | ((c + i) & m);
  endfunction

  // present start at negedge, consumed at next posedge
  task automatic kick(input logic [1:0] b, input bit o, input int c, input bit en);
    blc = b; order = o; scol = COL_W'(c); start = 1; beat_en = en;
    @(negedge clk);
    start = 0; beat_en = 0;
  endtask

  // walk remaining beats from index first; on entry outputs show beat first
  task automatic walk(input int c, input int bl, input bit o, input int first, input string req);
    for (int i = first; i < bl; i++) begin
      chk(valid === 1'b1, req, valid, 1);
      chk(col === COL_W'(exp_col(c, bl, o, i)), req, col, exp_col(c, bl, o, i));
      chk(last === (i == bl - 1), "R7", last, i == bl - 1);
      beat_en = 1;
      @(negedge clk);
      beat_en = 0;
    end
    chk(valid === 1'b0, "R7", valid, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [COL_W-1:0] held;
    @(negedge clk);
    chk(valid === 0 && last === 0 && col === '0, "R1", col, 0);
    rst_n = 1;
    @(negedge clk);
    chk(valid === 0 && last === 0 && col === '0, "R1", {valid, last}, 0);

    // R3 R4 R5 R6 sweep: all codes, both orders, all low bits, two upper patterns
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 2; o++)
        for (int up = 0; up < 2; up++)
          for (int lo = 0; lo < 8; lo++) begin
            int c = (up ? 9'h1A8 : 9'h050) | lo;
            kick(2'(b), 1'(o), c, 0);
            chk(col === COL_W'(c), "R2", col, c);
            walk(c, blen(2'(b)), 1'(o), 0, o ? "R5" : "R4");
          end

    // R8 stall mid burst
    kick(2'b11, 0, 9'h0F5, 0);
    beat_en = 1; @(negedge clk); beat_en = 0;
    held = col;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(valid === 1 && col === held && last === 0, "R8", col, held);
    end
    walk(9'h0F5, 8, 0, 1, "R8");

    // R11 enable while idle
    held = col;
    beat_en = 1; @(negedge clk); @(negedge clk); beat_en = 0;
    chk(valid === 0 && col === held, "R11", col, held);

    // R9 interrupt with simultaneous enable
    kick(2'b11, 0, 9'h105, 0);
    beat_en = 1; @(negedge clk); @(negedge clk); beat_en = 0;
    chk(col === COL_W'(exp_col(9'h105, 8, 0, 2)), "R9", col, exp_col(9'h105, 8, 0, 2));
    kick(2'b10, 1, 9'h1A3, 1);
    chk(col === 9'h1A3, "R9", col, 9'h1A3);
    walk(9'h1A3, 4, 1, 0, "R9");

    // R10 settings changed during burst
    kick(2'b10, 0, 9'h036, 0);
    blc = 2'b11; order = 1;
    walk(9'h036, 4, 0, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule